// File: doc/BRIEF.md
# Four-Way Set-Associative Byte Cache with LRU Replacement

This block caches a 16-bit, byte-addressable memory in 512 bytes of storage. The storage is held as sixteen sets of four 8-byte lines. A requester issues one byte operation at a time, either a read or a write. A read returns the whole 8-byte line that holds the addressed byte, a flag saying whether the line was already resident, and the dirty state that line had before the access. Writes are absorbed into the cache. A write miss first brings the line in, then merges the byte, and the line becomes dirty.

On a miss the controller chooses a victim. It takes an empty way first. If the set is full, it takes the way used longest ago. A modified victim is sent back to memory as a whole line in the same cycle that the new line is requested. The memory side is a simple line-wide port: a write strobe with address and data, and a read strobe whose data returns one cycle later. Line addresses are always multiples of eight. Memory and cache both start out as zeros.

Top module: `sa4_lru_cache`

## Requirements
- R1: After reset `ready` is 1, `resp_valid` is 0, no memory strobe is active and every line is invalid, so the first read of any address misses and returns an all-zero line with dirty 0.
- R2: The address is split as byte offset = bits [2:0], set = bits [6:3] and tag = bits [15:7]. An access hits (`resp_hit` = 1) when one of the four valid ways of its set holds the same tag.
- R3: A read (command byte 0x00) yields one `resp_valid` pulse. `resp_line` bits [8k+7:8k] carry the byte at line offset k. On a miss the line is the one just fetched from memory and `resp_hit` is 0.
- R4: `resp_dirty` reports the dirty bit as it stood before the access. On a hit this is the bit of the hit line. On a miss it is the bit of the victim way, and 0 if that way was invalid.
- R5: A write (command byte 0xFF) replaces the addressed byte and marks the line dirty. A write miss first fills the line from memory and then merges the byte. Writes give no response pulse.
- R6: Any other command byte is ignored. `ready` stays 1, no response is produced, no memory strobe fires and no cached byte changes.
- R7: A miss fills the lowest-numbered invalid way of the set. When the set has no invalid way, it evicts the way least recently touched, where both hits and fills count as touches. The recency order is held as a 2-bit age per way: a touched way becomes age 0, and the ways younger than its former age each gain one.
- R8: Evicting a dirty victim raises `mem_we` for exactly one cycle, with `mem_wr_addr` = {victim tag, set, 3'b000} and the full victim line. A clean or invalid victim raises no write.
- R9: Each miss reads memory at {tag, set, 3'b000}. A line that was evicted dirty and is later fetched again returns the data that was written before the eviction.
- R10: A hit completes in one cycle: `ready` stays high, and a read's response appears in the following cycle. A miss holds `ready` low for two cycles, and the response and `ready` return in the third cycle after acceptance.
- R11: Every miss raises `mem_re` for exactly one cycle, and a hit raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `ready` is 1 |
| req_addr | input | 16 | Byte address |
| req_cmd | input | 8 | 0x00 read, 0xFF write, other values ignored |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle, able to take a request |
| resp_valid | output | 1 | One-cycle pulse carrying a read result |
| resp_line | output | 64 | Line holding the read byte, lowest address in bits [7:0] |
| resp_hit | output | 1 | Read found its line resident |
| resp_dirty | output | 1 | Dirty state of the involved line before the access |
| mem_we | output | 1 | Write a victim line to memory |
| mem_wr_addr | output | 16 | Byte address of the victim line, multiple of 8 |
| mem_wr_data | output | 64 | Victim line contents |
| mem_re | output | 1 | Request a line from memory |
| mem_rd_addr | output | 16 | Byte address of the requested line, multiple of 8 |
| mem_rd_data | input | 64 | Requested line, valid the cycle after `mem_re` |

## Verification
The bench targets the points where a replacement policy usually goes wrong. It re-touches a full set out of fill order and then misses twice. A design that aged the ways on fills only, or that failed to increment the ways younger than the one touched, writes back the wrong victim address. A dirty line is pushed out and read back. Losing the write-back or sending it to the new tag's address returns zeros instead of the stored byte. Other checks cover the dirty flag on a miss into an empty way, and a write miss that must merge into fetched data rather than into a zero line. A stray command byte must leave every line and strobe untouched. A long pseudo-random mix confined to a few sets and tags keeps all four ways turning over.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;
    parameter int ADDR_W     = 16;
    parameter int LINE_BYTES = 8;
    parameter int NUM_WAYS   = 4;
    parameter int NUM_SETS   = 16;

    parameter int OFF_W  = $clog2(LINE_BYTES);
    parameter int SET_W  = $clog2(NUM_SETS);
    parameter int TAG_W  = ADDR_W - OFF_W - SET_W;
    parameter int WAY_W  = $clog2(NUM_WAYS);
    parameter int LINE_W = LINE_BYTES * 8;

    parameter logic [7:0] CMD_RD = 8'h00;
    parameter logic [7:0] CMD_WR = 8'hFF;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        tag_t tag;
        set_t set;
        off_t off;
    } addr_t;

    typedef struct packed {
        addr_t      addr;
        logic       wr;
        logic [7:0] data;
    } req_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } state_t;

    function automatic line_t put_byte(line_t l, off_t off, logic [7:0] b);
        line_t r;
        r = l;
        r[{off, 3'b000} +: 8] = b;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] line_base(tag_t t, set_t s);
        return {t, s, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/sa4_tag_store.sv
module sa4_tag_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter int TW   = 9,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SW-1:0]           lk_set,
    input  logic [TW-1:0]           lk_tag,
    output logic [WAYS-1:0]         lk_valid,
    output logic [WAYS-1:0]         lk_dirty,
    output logic [WAYS-1:0]         lk_hit,
    output logic [WAYS-1:0][TW-1:0] lk_tags,
    input  logic                    upd_en,
    input  logic [SW-1:0]           upd_set,
    input  logic [WW-1:0]           upd_way,
    input  logic [TW-1:0]           upd_tag,
    input  logic                    upd_dirty
);
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    logic [TW-1:0]   tag_q   [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else if (upd_en) begin
            valid_q[upd_set][upd_way] <= 1'b1;
            dirty_q[upd_set][upd_way] <= upd_dirty;
            tag_q[upd_set][upd_way]   <= upd_tag;
        end
    end

    assign lk_valid = valid_q[lk_set];
    assign lk_dirty = dirty_q[lk_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_tags[w] = tag_q[lk_set][w];
        assign lk_hit[w]  = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end
endmodule

// File: rtl/sa4_line_store.sv
module sa4_line_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter int LW   = 64,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rd_set,
    input  logic [WW-1:0] rd_way,
    output logic [LW-1:0] rd_line,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  logic [WW-1:0] wr_way,
    input  logic [LW-1:0] wr_line
);
    logic [LW-1:0] line_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) line_q[s][w] <= '0;
        end else if (wr_en) begin
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_set][rd_way];
endmodule

// File: rtl/sa4_lru_ages.sv
module sa4_lru_ages #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int SW  = $clog2(SETS),
    localparam int WW  = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW-1:0]   q_set,
    input  logic [WAYS-1:0] q_valid,
    output logic [WW-1:0]   victim_way,
    input  logic            touch_en,
    input  logic [SW-1:0]   touch_set,
    input  logic [WW-1:0]   touch_way
);
    logic [WW-1:0] age_q [SETS][WAYS];
    logic [WW-1:0] touched_age;

    assign touched_age = age_q[touch_set][touch_way];

    // ages form a permutation of 0..WAYS-1 in every set at all times
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WW'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < touched_age)
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !q_valid[w]) begin
                victim_way = WW'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (age_q[q_set][w] == WW'(WAYS - 1)) victim_way = WW'(w);
        end
    end
endmodule

// File: rtl/sa4_lru_cache.sv
module sa4_lru_cache
    import sa4_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_cmd,
    input  logic [7:0]        req_wdata,
    output logic              ready,
    output logic              resp_valid,
    output logic [LINE_W-1:0] resp_line,
    output logic              resp_hit,
    output logic              resp_dirty,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [LINE_W-1:0] mem_rd_data
);
    state_t st_q;
    req_t   req_q;
    way_t   vic_q;

    addr_t in_addr, cur_addr;
    logic  in_wr, cmd_ok, accept, hit_any, hit_go, miss_go, vic_dirty;
    way_t  hit_way, rd_way, victim_way;
    line_t rd_line;

    logic [NUM_WAYS-1:0]            lk_valid, lk_dirty, lk_hit;
    logic [NUM_WAYS-1:0][TAG_W-1:0] lk_tags;

    logic  upd_en, upd_dirty;
    set_t  upd_set;
    way_t  upd_way;
    tag_t  upd_tag;
    logic  wr_en;
    line_t wr_line;

    assign in_addr  = addr_t'(req_addr);
    assign in_wr    = (req_cmd == CMD_WR);
    assign cmd_ok   = (req_cmd == CMD_RD) || in_wr;
    assign ready    = (st_q == ST_IDLE);
    assign accept   = ready && req_valid && cmd_ok;
    assign cur_addr = ready ? in_addr : req_q.addr;

    assign hit_any = |lk_hit;
    assign hit_go  = accept && hit_any;
    assign miss_go = accept && !hit_any;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (lk_hit[w]) hit_way = way_t'(w);
    end

    assign rd_way    = ready ? hit_way : vic_q;
    assign vic_dirty = lk_valid[vic_q] && lk_dirty[vic_q];

    sa4_tag_store #(.WAYS(NUM_WAYS), .SETS(NUM_SETS), .TW(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_set   (cur_addr.set),
        .lk_tag   (cur_addr.tag),
        .lk_valid (lk_valid),
        .lk_dirty (lk_dirty),
        .lk_hit   (lk_hit),
        .lk_tags  (lk_tags),
        .upd_en   (upd_en),
        .upd_set  (upd_set),
        .upd_way  (upd_way),
        .upd_tag  (upd_tag),
        .upd_dirty(upd_dirty)
    );

    sa4_line_store #(.WAYS(NUM_WAYS), .SETS(NUM_SETS), .LW(LINE_W)) u_lines (
        .clk    (clk),
        .rst    (rst),
        .rd_set (cur_addr.set),
        .rd_way (rd_way),
        .rd_line(rd_line),
        .wr_en  (wr_en),
        .wr_set (upd_set),
        .wr_way (upd_way),
        .wr_line(wr_line)
    );

    sa4_lru_ages #(.WAYS(NUM_WAYS), .SETS(NUM_SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .q_set     (cur_addr.set),
        .q_valid   (lk_valid),
        .victim_way(victim_way),
        .touch_en  (upd_en),
        .touch_set (upd_set),
        .touch_way (upd_way)
    );

    // store updates: a hit in idle, or the arrival of a refill line
    always_comb begin
        upd_en    = 1'b0;
        upd_set   = cur_addr.set;
        upd_way   = rd_way;
        upd_tag   = cur_addr.tag;
        upd_dirty = 1'b0;
        wr_en     = 1'b0;
        wr_line   = rd_line;
        if (hit_go) begin
            upd_en    = 1'b1;
            upd_way   = hit_way;
            upd_dirty = lk_dirty[hit_way] || in_wr;
            wr_en     = in_wr;
            wr_line   = put_byte(rd_line, in_addr.off, req_wdata);
        end else if (st_q == ST_FILL) begin
            upd_en    = 1'b1;
            upd_way   = vic_q;
            upd_dirty = req_q.wr;
            wr_en     = 1'b1;
            wr_line   = req_q.wr ? put_byte(mem_rd_data, req_q.addr.off, req_q.data)
                                 : mem_rd_data;
        end
    end

    assign mem_re      = (st_q == ST_EVICT);
    assign mem_we      = (st_q == ST_EVICT) && vic_dirty;
    assign mem_wr_addr = line_base(lk_tags[vic_q], req_q.addr.set);
    assign mem_wr_data = rd_line;
    assign mem_rd_addr = line_base(req_q.addr.tag, req_q.addr.set);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            req_q      <= '0;
            vic_q      <= '0;
            resp_valid <= 1'b0;
            resp_line  <= '0;
            resp_hit   <= 1'b0;
            resp_dirty <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (hit_go && !in_wr) begin
                        resp_valid <= 1'b1;
                        resp_line  <= rd_line;
                        resp_hit   <= 1'b1;
                        resp_dirty <= lk_dirty[hit_way];
                    end
                    if (miss_go) begin
                        req_q <= '{addr: in_addr, wr: in_wr, data: req_wdata};
                        vic_q <= victim_way;
                        st_q  <= ST_EVICT;
                    end
                end
                ST_EVICT: st_q <= ST_FILL;
                ST_FILL: begin
                    if (!req_q.wr) begin
                        resp_valid <= 1'b1;
                        resp_line  <= mem_rd_data;
                        resp_hit   <= 1'b0;
                        resp_dirty <= vic_dirty;
                    end
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sa4_cache_checker.sv
module sa4_cache_checker
    import sa4_cache_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [7:0] req_cmd,
    input logic       ready,
    input logic       resp_valid,
    input logic       resp_hit,
    input logic       mem_we,
    input logic       mem_re
);
    // R10: responses only surface when the controller is idle again
    p_resp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ready);

    // R8: a write-back only happens alongside a refill request
    p_wb_with_refill_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_re);

    // R11: refill request is a single-cycle strobe, controller still busy
    p_single_refill_r11: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (!mem_re && !ready));

    // R10: two cycles after the refill request the controller is free
    p_miss_done_r10: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> ##1 ready);

    // R3: a response completing a miss never claims a hit
    p_miss_no_hit_r3: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> ##1 (resp_valid |-> !resp_hit));

    // R6: unknown command bytes leave the controller untouched
    p_bad_cmd_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready && req_cmd != CMD_RD && req_cmd != CMD_WR)
        |=> (ready && !resp_valid && !mem_re));

    // R10: a hit response follows an idle cycle
    p_hit_fast_r10: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> $past(ready));
endmodule

bind sa4_lru_cache sa4_cache_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .ready     (ready),
    .resp_valid(resp_valid),
    .resp_hit  (resp_hit),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/sa4_lru_cache_bench.sv
`timescale 1ns/1ps
module sa4_lru_cache_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_cmd = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, resp_valid, resp_hit, resp_dirty;
    logic [63:0] resp_line;
    logic        mem_we, mem_re;
    logic [15:0] mem_wr_addr, mem_rd_addr;
    logic [63:0] mem_wr_data;
    logic [63:0] mem_rd_data = '0;

    int tests = 0;
    int fails = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    sa4_lru_cache u_sa4_lru_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .ready(ready),
        .resp_valid(resp_valid), .resp_line(resp_line), .resp_hit(resp_hit),
        .resp_dirty(resp_dirty), .mem_we(mem_we), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_re(mem_re), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    // memory the cache talks to
    logic [63:0] ram [logic [15:0]];
    int          wb_cnt, re_cnt;
    logic [15:0] wb_addr, re_addr;
    logic [63:0] wb_data;

    always @(posedge clk) begin
        if (!rst && mem_we) begin
            ram[mem_wr_addr] = mem_wr_data;
            wb_cnt++;
            wb_addr = mem_wr_addr;
            wb_data = mem_wr_data;
        end
        if (!rst && mem_re) begin
            mem_rd_data <= ram.exists(mem_rd_addr) ? ram[mem_rd_addr] : 64'd0;
            re_cnt++;
            re_addr = mem_rd_addr;
        end
    end

    // behavioural reference
    bit          m_valid [16][4];
    bit          m_dirty [16][4];
    int          m_tag   [16][4];
    int          m_age   [16][4];
    logic [63:0] m_data  [16][4];
    logic [63:0] m_ram   [int];

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic touch(input int s, input int w);
        int old = m_age[s][w];
        for (int x = 0; x < 4; x++) if (m_age[s][x] < old) m_age[s][x]++;
        m_age[s][w] = 0;
    endtask

    function automatic logic [15:0] mk(input int tag, input int set, input int off);
        return {tag[8:0], set[3:0], off[2:0]};
    endfunction

    task automatic run_op(input logic [15:0] a, input logic [7:0] c, input logic [7:0] d, input string rq);
        int s = int'(a[6:3]);
        int t = int'(a[15:7]);
        int off = int'(a[2:0]);
        bit ok_cmd = (c == 8'h00) || (c == 8'hFF);
        bit wr = (c == 8'hFF);
        bit e_hit = 0, e_dirty = 0, e_wb = 0;
        int w = 0, lat = 1, cyc;
        logic [15:0] e_wb_addr = '0, e_re_addr = '0;
        logic [63:0] e_wb_data = '0, e_line = '0, ln;
        if (ok_cmd) begin
            for (int x = 0; x < 4; x++)
                if (m_valid[s][x] && m_tag[s][x] == t) begin e_hit = 1; w = x; end
            if (e_hit) begin
                e_dirty = m_dirty[s][w];
            end else begin
                bit found = 0;
                for (int x = 0; x < 4; x++)
                    if (!found && !m_valid[s][x]) begin w = x; found = 1; end
                if (!found)
                    for (int x = 0; x < 4; x++) if (m_age[s][x] == 3) w = x;
                e_dirty = m_valid[s][w] && m_dirty[s][w];
                if (e_dirty) begin
                    e_wb = 1;
                    e_wb_addr = mk(m_tag[s][w], s, 0);
                    e_wb_data = m_data[s][w];
                    m_ram[int'(e_wb_addr)] = e_wb_data;
                end
                e_re_addr = mk(t, s, 0);
                m_data[s][w]  = m_ram.exists(int'(e_re_addr)) ? m_ram[int'(e_re_addr)] : 64'd0;
                m_valid[s][w] = 1;
                m_dirty[s][w] = 0;
                m_tag[s][w]   = t;
                lat = 3;
            end
            e_line = m_data[s][w];
            if (wr) begin
                ln = m_data[s][w];
                ln[off*8 +: 8] = d;
                m_data[s][w]  = ln;
                m_dirty[s][w] = 1;
            end
            touch(s, w);
        end
        wb_cnt = 0;
        re_cnt = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_cmd = c; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        cyc = 1;
        while (!ready && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == lat, "R10 latency", 64'(cyc), 64'(lat));
        chk(resp_valid == (ok_cmd && !wr), ok_cmd ? "R3 response pulse" : "R6 response pulse",
            64'(resp_valid), 64'(ok_cmd && !wr));
        if (ok_cmd && !wr) begin
            chk(resp_line == e_line, rq, resp_line, e_line);
            chk(resp_hit == e_hit, "R2 hit flag", 64'(resp_hit), 64'(e_hit));
            chk(resp_dirty == e_dirty, "R4 dirty flag", 64'(resp_dirty), 64'(e_dirty));
        end
        chk(wb_cnt == int'(e_wb), "R8 write-back count", 64'(wb_cnt), 64'(e_wb));
        if (e_wb) begin
            chk(wb_addr == e_wb_addr, "R8 write-back address", 64'(wb_addr), 64'(e_wb_addr));
            chk(wb_data == e_wb_data, "R8 write-back data", wb_data, e_wb_data);
        end
        chk(re_cnt == ((ok_cmd && !e_hit) ? 1 : 0), "R11 refill count", 64'(re_cnt), 64'(ok_cmd && !e_hit));
        if (ok_cmd && !e_hit)
            chk(re_addr == e_re_addr, "R9 refill address", 64'(re_addr), 64'(e_re_addr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
                m_age[s][w] = w; m_data[s][w] = '0;
            end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle state after reset
        chk(ready == 1'b1, "R1 ready after reset", 64'(ready), 64'd1);
        chk(resp_valid == 1'b0, "R1 no response after reset", 64'(resp_valid), 64'd0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R1 no memory strobe", 64'({mem_we, mem_re}), 64'd0);

        // R1: cold read misses with a zero line
        run_op(16'h856C, 8'h00, 8'h00, "R1 cold line");
        // R5: write hit, then read it back dirty
        run_op(16'h856C, 8'hFF, 8'h2E, "R5 write hit");
        run_op(16'h856C, 8'h00, 8'h00, "R5 byte merged");
        // R5: write miss allocates into fetched data
        run_op(16'h3F6F, 8'hFF, 8'hD9, "R5 write miss");
        run_op(16'h3F68, 8'h00, 8'h00, "R5 line after write miss");
        // R6: stray command leaves the line as is
        run_op(16'h856C, 8'h5A, 8'h77, "R6 ignored");
        run_op(16'h856C, 8'h00, 8'h00, "R6 line unchanged");

        // R7: fill set 5 in way order, reshuffle recency, then evict
        for (int t = 1; t <= 4; t++) run_op(mk(t, 5, t), 8'hFF, 8'(8'h10 + t), "R7 fill");
        run_op(mk(1, 5, 0), 8'h00, 8'h00, "R7 touch oldest");
        run_op(mk(3, 5, 0), 8'h00, 8'h00, "R7 touch third");
        run_op(mk(9, 5, 0), 8'h00, 8'h00, "R7 evicts least recent");
        run_op(mk(2, 5, 0), 8'h00, 8'h00, "R9 evicted line returns");
        run_op(mk(4, 5, 4), 8'h00, 8'h00, "R9 second round trip");

        // R9: push the dirty line of the first set out and fetch it back
        for (int t = 20; t < 24; t++) run_op(mk(t, int'(16'h856C >> 3) & 15, 0), 8'h00, 8'h00, "R9 pressure");
        run_op(16'h856C, 8'h00, 8'h00, "R9 stored byte survives eviction");

        // R2/R7: pseudo-random traffic over few sets and tags
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [7:0] c;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            c = (lf[2:0] == 3'd7) ? 8'h3C : (lf[3] ? 8'hFF : 8'h00);
            run_op(mk(int'(lf[15:13]), int'(lf[5:4]) + 8, int'(lf[8:6])), c, lf[12:5], "R3 random line");
        end
        summary();
        $finish;
    end
endmodule